// File: doc/BRIEF.md
# RAM-Backed Serial Command Broadcaster

This block keeps two small command stores that the host writes one byte at a time. It sends the whole contents of either store over one shared three-wire serial link: a clock, a data line and a latch strobe. The first store holds N two-byte commands for an on-screen display controller. An accepted write into its low-byte half starts a burst of every command. While that burst runs, a dedicated active-low select is held low.

The second store holds seven control bytes for parallel latch devices on a board. An accepted write to its address 6 starts a burst of all seven bytes. After the last bit, a strobe pulse tells the latch devices to take the shifted data.

Only one burst uses the link at a time. A trigger for the other store that arrives during a burst waits its turn, and the display store wins when both are waiting. A host write to the store that is being shifted is held off with a ready signal until that burst ends. A status byte reports which burst is running.

Top module: `serial_cmd_bcast`

## Requirements
- R1: Out of reset, the outputs are as follows: `sclk` is 1, `disp_cs_n` is 1, `reg_strobe` is 0, `sdata` is 0, `status` is 0 and `host_ready` is 1.
- R2: An accepted write with `host_space`=01 and an address below N_CMD stores the display low byte and starts a display burst. The burst sends commands 0 to N_CMD-1 in that order. Each command goes high byte (space 00) first, then low byte (space 01), MSB first, for 16·N_CMD bits in all.
- R3: `disp_cs_n` is 0 on every bit of a display burst. It is 1 on every bit of a control burst and while the link is idle.
- R4: `status` bit 6 is 1 while a display burst shifts. `status` bit 5 is 1 while a control burst shifts and during its strobe. The two bits are never 1 together, and the other status bits are 0.
- R5: `sclk` idles high. Each bit starts with a falling edge of `sclk` and has its rising edge in mid-bit. `sdata` changes only together with a falling edge, so a receiver samples it on the rising edge. One bit lasts 2·HALF_DIV clock cycles.
- R6: An accepted write with `host_space`=10 stores a control byte. A write to address 6 also starts a control burst of bytes 0 to 6, MSB first (56 bits). Writes to addresses 0 to 5 start nothing.
- R7: After the last bit of a control burst, `reg_strobe` goes high exactly once, for 2·HALF_DIV clock cycles, with `sclk` high. A display burst is never followed by a strobe.
- R8: A trigger for one store that is accepted during a burst of the other store is held. Its burst follows once the current burst (and its strobe) has ended.
- R9: When both triggers are waiting at the end of a burst, the display burst is sent first and the control burst after it.
- R10: A write to the store currently being shifted sees `host_ready` at 0 and is not taken until the burst ends. The running burst sends the old contents.
- R11: Writes with `host_space`=11, or to control address 7 or above, change no stored byte and start no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write request |
| host_space | input | 2 | Target: 00 display high bytes, 01 display low bytes, 10 control bytes |
| host_addr | input | IW | Entry index within the target store |
| host_wdata | input | 8 | Byte to write |
| host_ready | output | 1 | High when a write in this cycle is taken |
| status | output | 8 | Bit 6 display burst, bit 5 control burst |
| sclk | output | 1 | Shared serial clock |
| sdata | output | 1 | Shared serial data |
| reg_strobe | output | 1 | Latch strobe after a control burst |
| disp_cs_n | output | 1 | Active-low select of the display controller |

## Verification
The assertions check on every cycle the properties of the link that do not depend on data. The strobe only appears with the select high and the clock high. Data stays fixed through the high half of each display bit. The link rests with the clock high and nothing selected. The two busy flags never overlap, and a display write during a display burst is refused.

The bench scenarios are needed for the rest, which depends on ordering and content. These are the exact bit stream and its byte order, the held trigger and the order of served triggers, old contents going out when a write is stalled, the strobe count and width, and writes that start nothing.

// File: rtl/serial_cmd_bcast.sv
module serial_cmd_bcast #(
  parameter int N_CMD    = 8,
  parameter int HALF_DIV = 2,
  localparam int IW = $clog2((2 * N_CMD > 8) ? 2 * N_CMD : 8),
  localparam int DW = $clog2(2 * HALF_DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [1:0]    host_space,
  input  logic [IW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic          host_ready,
  output logic [7:0]    status,
  output logic          sclk,
  output logic          sdata,
  output logic          reg_strobe,
  output logic          disp_cs_n
);

  localparam logic [IW-1:0] D_LIMIT  = IW'(N_CMD);
  localparam logic [IW-1:0] D_LASTB  = IW'(2 * N_CMD - 1);
  localparam logic [IW-1:0] C_LASTB  = IW'(6);
  localparam logic [DW-1:0] HALF_END = DW'(HALF_DIV - 1);
  localparam logic [DW-1:0] STRB_END = DW'(2 * HALF_DIV - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_STRB} st_t;

  logic [7:0] d_hi  [2**(IW-1)];
  logic [7:0] d_lo  [2**(IW-1)];
  logic [7:0] c_ram [2**IW];

  st_t           state;
  logic          mode_d, pend_d, pend_c, phase, sclk_q;
  logic [IW-1:0] bidx;
  logic [2:0]    bpos;
  logic [DW-1:0] dcnt;

  logic d_busy, c_busy, acc, d_ok, c_ok, trig_d, trig_c, start_d, start_c, last_bit;
  logic [7:0] cur_byte;

  assign d_busy = (state == ST_SHIFT) && mode_d;
  assign c_busy = ((state == ST_SHIFT) && !mode_d) || (state == ST_STRB);

  assign host_ready = !((!host_space[1] && d_busy) ||
                        (host_space == 2'b10 && state == ST_SHIFT && !mode_d));
  assign acc    = host_wr && host_ready;
  assign d_ok   = host_addr < D_LIMIT;
  assign c_ok   = host_addr <= C_LASTB;
  assign trig_d = acc && host_space == 2'b01 && d_ok;
  assign trig_c = acc && host_space == 2'b10 && host_addr == C_LASTB;

  assign start_d = (state == ST_IDLE) && pend_d;
  assign start_c = (state == ST_IDLE) && !pend_d && pend_c;

  assign cur_byte = mode_d ? (bidx[0] ? d_lo[bidx[IW-1:1]] : d_hi[bidx[IW-1:1]])
                           : c_ram[bidx];
  assign last_bit = (bpos == 3'd0) && (bidx == (mode_d ? D_LASTB : C_LASTB));

  assign sclk       = sclk_q;
  assign sdata      = (state == ST_SHIFT) ? cur_byte[bpos] : 1'b0;
  assign reg_strobe = (state == ST_STRB);
  assign disp_cs_n  = !d_busy;
  assign status     = {1'b0, d_busy, c_busy, 5'b0};

  always_ff @(posedge clk) begin
    if (acc) begin
      if (host_space == 2'b00 && d_ok) d_hi[host_addr[IW-2:0]] <= host_wdata;
      if (host_space == 2'b01 && d_ok) d_lo[host_addr[IW-2:0]] <= host_wdata;
      if (host_space == 2'b10 && c_ok) c_ram[host_addr]        <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_d <= 1'b0;
      pend_d <= 1'b0;
      pend_c <= 1'b0;
      phase  <= 1'b0;
      sclk_q <= 1'b1;
      bidx   <= '0;
      bpos   <= 3'd7;
      dcnt   <= '0;
    end else begin
      pend_d <= (pend_d && !start_d) || trig_d;
      pend_c <= (pend_c && !start_c) || trig_c;
      case (state)
        ST_IDLE: begin
          if (pend_d || pend_c) begin
            state  <= ST_SHIFT;
            mode_d <= pend_d;
            bidx   <= '0;
            bpos   <= 3'd7;
            dcnt   <= '0;
            phase  <= 1'b0;
            sclk_q <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (dcnt == HALF_END) begin
            dcnt <= '0;
            if (!phase) begin
              sclk_q <= 1'b1;
              phase  <= 1'b1;
            end else if (last_bit) begin
              state <= mode_d ? ST_IDLE : ST_STRB;
            end else begin
              sclk_q <= 1'b0;
              phase  <= 1'b0;
              if (bpos == 3'd0) begin
                bpos <= 3'd7;
                bidx <= bidx + IW'(1);
              end else begin
                bpos <= bpos - 3'd1;
              end
            end
          end else begin
            dcnt <= dcnt + DW'(1);
          end
        end
        ST_STRB: begin
          if (dcnt == STRB_END) begin
            dcnt  <= '0;
            state <= ST_IDLE;
          end else begin
            dcnt <= dcnt + DW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_cmd_bcast_chk.sv
module serial_cmd_bcast_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic [1:0] host_space,
  input logic       host_ready,
  input logic [7:0] status,
  input logic       sclk,
  input logic       sdata,
  input logic       reg_strobe,
  input logic       disp_cs_n
);

  AST_STRB_NOT_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_strobe |-> disp_cs_n); // R7

  AST_STRB_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    reg_strobe |-> sclk); // R7

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk) && !disp_cs_n && !$past(disp_cs_n)) |-> $stable(sdata)); // R5

  AST_IDLE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6:5] == 2'b00) |-> (sclk && disp_cs_n && !reg_strobe)); // R5

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[6] && status[5])); // R4

  AST_DISP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_space[1] && status[6]) |-> !host_ready); // R10

endmodule

bind serial_cmd_bcast serial_cmd_bcast_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_space(host_space),
  .host_ready(host_ready), .status(status), .sclk(sclk), .sdata(sdata),
  .reg_strobe(reg_strobe), .disp_cs_n(disp_cs_n)
);

// File: tb/serial_cmd_bcast_tb.sv
`timescale 1ns/1ps
module serial_cmd_bcast_tb;
  localparam int N    = 8;
  localparam int HALF = 2;
  localparam int AW   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [1:0] host_space = 2'b00;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_ready, sclk, sdata, reg_strobe, disp_cs_n;
  logic [7:0] status;

  serial_cmd_bcast #(.N_CMD(N), .HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_space(host_space),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .status(status), .sclk(sclk), .sdata(sdata), .reg_strobe(reg_strobe),
    .disp_cs_n(disp_cs_n)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] sh_hi [N];
  logic [7:0] sh_lo [N];
  logic [7:0] sh_c  [7];
  logic cap_bit [1024];
  logic cap_cs  [1024];
  logic exp_bit [1024];
  logic exp_cs  [1024];
  int ncap = 0, nexp = 0, nstrb = 0, strb_at = 0, strb_clks = 0;
  int rise_t [2];
  bit saw6, saw5;

  always @(posedge clk) cyc++;
  always @(posedge clk) if (reg_strobe === 1'b1) strb_clks++;
  always @(posedge sclk) begin
    if (ncap < 1024) begin
      cap_bit[ncap] = sdata;
      cap_cs[ncap]  = disp_cs_n;
    end
    if (ncap < 2) rise_t[ncap] = cyc;
    ncap++;
  end
  always @(posedge reg_strobe) begin
    nstrb++;
    strb_at = ncap;
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_cap();
    ncap = 0; nexp = 0; nstrb = 0; strb_at = 0; strb_clks = 0;
    saw6 = 0; saw5 = 0;
  endtask

  task automatic wr(input logic [1:0] sp, input int a, input logic [7:0] d, output bit stalled);
    @(negedge clk);
    host_wr = 1'b1; host_space = sp; host_addr = AW'(a); host_wdata = d;
    #1;
    stalled = !host_ready;
    while (!host_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    host_wr = 1'b0;
    if (sp == 2'b00 && a < N) sh_hi[a] = d;
    if (sp == 2'b01 && a < N) sh_lo[a] = d;
    if (sp == 2'b10 && a < 7) sh_c[a]  = d;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      saw6 |= status[6];
      saw5 |= status[5];
      if (status[6:5] == 2'b00) q++; else q = 0;
    end
  endtask

  task automatic push_byte(input logic [7:0] b, input logic cs);
    for (int k = 7; k >= 0; k--) begin
      exp_bit[nexp] = b[k];
      exp_cs[nexp]  = cs;
      nexp++;
    end
  endtask

  task automatic exp_disp();
    for (int i = 0; i < N; i++) begin
      push_byte(sh_hi[i], 1'b0);
      push_byte(sh_lo[i], 1'b0);
    end
  endtask

  task automatic exp_ctl();
    for (int i = 0; i < 7; i++) push_byte(sh_c[i], 1'b1);
  endtask

  task automatic cmp(input string req);
    int bad = -1;
    chk(req, ncap == nexp, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++)
      if (bad < 0 && (cap_bit[i] !== exp_bit[i] || cap_cs[i] !== exp_cs[i])) bad = i;
    chk(req, bad < 0, bad, -1);
  endtask

  task automatic t_reset();
    chk("R1 sclk", sclk === 1'b1, sclk, 1);
    chk("R1 cs_n", disp_cs_n === 1'b1, disp_cs_n, 1);
    chk("R1 strobe", reg_strobe === 1'b0, reg_strobe, 0);
    chk("R1 sdata", sdata === 1'b0, sdata, 0);
    chk("R1 status", status === 8'h00, status, 0);
    chk("R1 ready", host_ready === 1'b1, host_ready, 1);
  endtask

  task automatic t_load();
    bit s;
    for (int i = 0; i < N; i++) wr(2'b00, i, 8'(8'h81 + 37 * i), s);
    for (int i = 0; i < 6; i++) wr(2'b10, i, 8'(8'h3C ^ (19 * i)), s);
    clr_cap();
    repeat (30) @(negedge clk);
    chk("R6 no burst on addr 0-5", ncap == 0, ncap, 0);
    for (int i = 0; i < N; i++) wr(2'b01, i, 8'(8'hE4 - 23 * i), s);
    wait_idle();
  endtask

  task automatic t_disp();
    bit s;
    clr_cap();
    wr(2'b01, N - 1, sh_lo[N-1], s);
    wait_idle();
    exp_disp();
    cmp("R2 R3 display stream");
    chk("R4 status bit6 seen", saw6, saw6, 1);
    chk("R7 no strobe after display", nstrb == 0, nstrb, 0);
    chk("R5 bit period", rise_t[1] - rise_t[0] == 2 * HALF, rise_t[1] - rise_t[0], 2 * HALF);
  endtask

  task automatic t_ctl();
    bit s;
    clr_cap();
    wr(2'b10, 6, 8'hA5, s);
    wait_idle();
    exp_ctl();
    cmp("R6 R3 control stream");
    chk("R4 status bit5 seen", saw5 && !saw6, saw5, 1);
    chk("R7 strobe count", nstrb == 1, nstrb, 1);
    chk("R7 strobe after last bit", strb_at == 56, strb_at, 56);
    chk("R7 strobe width", strb_clks == 2 * HALF, strb_clks, 2 * HALF);
  endtask

  task automatic t_ignore();
    bit s;
    logic [7:0] keep [7];
    for (int i = 0; i < 7; i++) keep[i] = sh_c[i];
    clr_cap();
    wr(2'b11, 1, 8'h00, s);
    wr(2'b11, 6, 8'h00, s);
    wr(2'b10, 7, 8'h00, s);
    wr(2'b10, 9, 8'hFF, s);
    repeat (40) @(negedge clk);
    chk("R11 no burst", ncap == 0 && status == 0, ncap, 0);
    clr_cap();
    wr(2'b10, 6, sh_c[6], s);
    wait_idle();
    for (int i = 0; i < 7; i++) sh_c[i] = keep[i];
    exp_ctl();
    cmp("R11 contents unchanged");
  endtask

  task automatic t_pending();
    bit s;
    clr_cap();
    wr(2'b01, 0, sh_lo[0], s);
    while (!status[6]) @(negedge clk);
    wr(2'b10, 6, 8'h5A, s);
    chk("R8 control write not stalled", !s, s, 0);
    wait_idle();
    exp_disp();
    exp_ctl();
    cmp("R8 held control burst follows");
  endtask

  task automatic t_stall();
    bit s;
    logic [7:0] nv;
    clr_cap();
    wr(2'b01, 2, sh_lo[2], s);
    while (!status[6]) @(negedge clk);
    exp_disp();
    nv = ~sh_hi[0];
    wr(2'b00, 0, nv, s);
    chk("R10 ready low during own burst", s, s, 1);
    wait_idle();
    cmp("R10 old contents sent");
    clr_cap();
    wr(2'b01, 2, sh_lo[2], s);
    wait_idle();
    exp_disp();
    cmp("R10 new contents after burst");
  endtask

  task automatic t_prio();
    bit s;
    clr_cap();
    wr(2'b10, 6, 8'hC3, s);
    while (!status[5]) @(negedge clk);
    wr(2'b01, 1, 8'h6E, s);
    while (!reg_strobe) @(negedge clk);
    wr(2'b10, 6, 8'h17, s);
    chk("R9 control write taken during strobe", !s, s, 0);
    wait_idle();
    sh_c[6] = 8'hC3;
    exp_ctl();
    exp_disp();
    sh_c[6] = 8'h17;
    exp_ctl();
    cmp("R9 display served before control");
    chk("R9 strobe count", nstrb == 2, nstrb, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_disp();
    t_ctl();
    t_ignore();
    t_pending();
    t_stall();
    t_prio();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule